// File: doc/BRIEF.md
# Li-Ion Charge Cycle Sequencer

This block is the digital controller that runs one charge cycle for a single lithium cell. It does not measure anything itself. It reads comparator flags from the analog charger and drives the enable and current-select controls back into the current and voltage loops. The flags are low battery, constant-voltage regulation reached, battery below the recharge level, charge current under one tenth of the programmed value, thermistor hot, thermistor cold, thermistor input grounded, input undervoltage lockout, shutdown and suspend. A slow tick input, produced elsewhere, advances the two safety timers.

A cycle starts in one of two modes. If the cell is deeply discharged, it starts with a reduced trickle current. Otherwise it starts with full constant current. The cycle then moves to top-off once voltage regulation is seen. It terminates when the top-off timer runs out, or it aborts into a latched bad-battery fault if the trickle phase lasts too long.

After termination, the block starts a new cycle when the battery has stayed below the recharge threshold long enough. A thermistor fault pauses charging with both timers frozen. Any lockout, shutdown or suspend forces the idle state and clears the cycle. All timer lengths are parameters, so a bench can shorten them.

Top module: `chg_seq_top`

## Requirements
- R1: After reset, and while any of shutdown, undervoltage lockout or suspend is held, the state is OFF and chg_en, trickle_sel, eoc and bad_bat_flt are 0. The state codes on chg_state are: OFF=0, TRICKLE=1, FAST=2, TOPOFF=3, DONE=4, BAD=5, HOLD=6.
- R2: When a cycle starts with the low-battery flag set, the state becomes TRICKLE with chg_en=1 and trickle_sel=1. With the flag clear, the state becomes FAST with trickle_sel=0. trickle_sel is never 1 without chg_en.
- R3: After TRICKLE_TICKS ticks spent in TRICKLE, the state becomes BAD, with bad_bat_flt=1 and chg_en=0. BAD is kept even if the low-battery flag clears, and only shutdown, lockout or suspend leaves it.
- R4: In TRICKLE, a cleared low-battery flag moves the state to FAST.
- R5: Ticks do not count in FAST. The termination timer counts only from entry to TOPOFF. After TERM_TICKS ticks in TOPOFF, the state becomes DONE with chg_en=0.
- R6: In TOPOFF, the current-below-tenth flag sets eoc while chg_en stays 1. eoc is also 1 in DONE, and it clears when a new cycle starts.
- R7: In DONE, a new cycle starts only when the synchronized below-recharge flag has been high for at least DIP_CYCLES consecutive clock cycles. Shorter dips leave the state DONE.
- R8: A qualified dip of that kind while in TOPOFF resets the termination timer to zero, so a full TERM_TICKS ticks are needed again.
- R9: A thermistor hot or cold fault in TRICKLE, FAST or TOPOFF moves the state to HOLD with chg_en=0 and ntc_flt=1, and ticks do not advance the timers. On recovery with the battery below the recharge level, the previous phase resumes with the timer at its held value.
- R10: On thermistor recovery with the battery above the recharge level, the state becomes DONE and charging stays off.
- R11: While the thermistor-grounded flag is set, hot and cold flags have no effect and ntc_flt stays 0.
- R12: A lockout that goes high and then low restarts the cycle with the termination timer cleared.
- R13: Shutdown clears eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timer tick, synchronous |
| bat_low_a | input | 1 | Battery below the trickle threshold (async) |
| cv_mode_a | input | 1 | Voltage loop in regulation (async) |
| below_rechg_a | input | 1 | Battery below the recharge level (async) |
| cur_tenth_a | input | 1 | Charge current under one tenth of the programmed value (async) |
| ntc_hot_a | input | 1 | Thermistor too hot (async) |
| ntc_cold_a | input | 1 | Thermistor too cold (async) |
| ntc_gnd_a | input | 1 | Thermistor input grounded, masks temperature faults (async) |
| uvlo_a | input | 1 | Input undervoltage lockout (async) |
| shdn_a | input | 1 | Shutdown request (async) |
| susp_a | input | 1 | Suspend request (async) |
| chg_en | output | 1 | Charger enable |
| trickle_sel | output | 1 | Select the reduced trickle current |
| chg_state | output | 3 | Current state code |
| eoc | output | 1 | End-of-charge indication |
| bad_bat_flt | output | 1 | Latched bad-battery fault |
| ntc_flt | output | 1 | Temperature fault active |

## Verification
The bench sweeps the tick count through both timer limits and checks the state after every tick. A timer that is off by one would end trickle or top-off one tick early or one tick late. Recharge dips are swept from one cycle up to just past the qualification length. A filter that is too short or too long would restart at the wrong dip length.

Two runs target the timer-hold behaviour. One pauses top-off on a thermistor fault and checks that only the remaining ticks are needed afterwards; a design that clears the timer on a pause would stay in top-off too long. The other fires a qualified dip during top-off, and a lockout pulse, and checks that a full timer is needed again; a design that keeps the count would terminate early. Latching of the bad-battery fault is checked across a cleared low-battery flag, and the thermistor mask is checked with a hot flag present.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_TRICKLE = 3'd1,
    ST_FAST    = 3'd2,
    ST_TOPOFF  = 3'd3,
    ST_DONE    = 3'd4,
    ST_BAD     = 3'd5,
    ST_HOLD    = 3'd6
  } chg_st_t;

  // positions in the synchronized flag vector
  localparam int F_LOW   = 0;
  localparam int F_CV    = 1;
  localparam int F_BELOW = 2;
  localparam int F_TENTH = 3;
  localparam int F_HOT   = 4;
  localparam int F_COLD  = 5;
  localparam int F_GND   = 6;
  localparam int F_UVLO  = 7;
  localparam int F_SHDN  = 8;
  localparam int F_SUSP  = 9;
  localparam int NFLAG   = 10;
endpackage

// File: rtl/chg_flag_sync.sv
module chg_flag_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (run && tick && cnt != CW'(LIMIT))
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/chg_dip_filter.sv
module chg_dip_filter #(
  parameter int DIP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic below,
  output logic qual_lvl,
  output logic qual_pulse
);
  localparam int CW = $clog2(DIP + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !below)
      cnt <= '0;
    else if (cnt != CW'(DIP))
      cnt <= cnt + 1'b1;
  end

  assign qual_lvl   = (cnt == CW'(DIP));
  assign qual_pulse = below && (cnt == CW'(DIP - 1));
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inhibit,
  input  logic    low,
  input  logic    cv,
  input  logic    below,
  input  logic    tenth,
  input  logic    ntc_bad,
  input  logic    trk_exp,
  input  logic    term_exp,
  input  logic    dip_lvl,
  input  logic    dip_pulse,
  output chg_st_t state,
  output logic    trk_clr,
  output logic    trk_run,
  output logic    term_clr,
  output logic    term_run,
  output logic    chg_en,
  output logic    trickle_sel,
  output logic    eoc,
  output logic    bad_flt,
  output logic    ntc_flt
);
  chg_st_t nxt, resume_st;
  logic    cv_seen;

  assign resume_st = low ? ST_TRICKLE : (cv_seen ? ST_TOPOFF : ST_FAST);

  always_comb begin
    nxt = state;
    if (inhibit) nxt = ST_OFF;
    else begin
      case (state)
        ST_OFF:     nxt = ntc_bad ? ST_HOLD : (low ? ST_TRICKLE : ST_FAST);
        ST_TRICKLE: if (ntc_bad) nxt = ST_HOLD;
                    else if (trk_exp) nxt = ST_BAD;
                    else if (!low) nxt = ST_FAST;
        ST_FAST:    if (ntc_bad) nxt = ST_HOLD;
                    else if (cv) nxt = ST_TOPOFF;
        ST_TOPOFF:  if (ntc_bad) nxt = ST_HOLD;
                    else if (term_exp) nxt = ST_DONE;
        ST_DONE:    if (!ntc_bad && dip_lvl) nxt = low ? ST_TRICKLE : ST_FAST;
        ST_BAD:     nxt = ST_BAD;
        ST_HOLD:    if (!ntc_bad) nxt = below ? resume_st : ST_DONE;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  // timer control from the current state
  assign trk_run  = (state == ST_TRICKLE);
  assign trk_clr  = !(state == ST_TRICKLE || state == ST_HOLD);
  assign term_run = (state == ST_TOPOFF);
  assign term_clr = (state == ST_OFF) || (state == ST_TRICKLE) || (state == ST_FAST) ||
                    (state == ST_DONE) || (state == ST_BAD) ||
                    (state == ST_TOPOFF && dip_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OFF;
      cv_seen     <= 1'b0;
      chg_en      <= 1'b0;
      trickle_sel <= 1'b0;
      eoc         <= 1'b0;
      bad_flt     <= 1'b0;
      ntc_flt     <= 1'b0;
    end else begin
      state       <= nxt;
      chg_en      <= (nxt == ST_TRICKLE) || (nxt == ST_FAST) || (nxt == ST_TOPOFF);
      trickle_sel <= (nxt == ST_TRICKLE);
      bad_flt     <= (nxt == ST_BAD);
      ntc_flt     <= ntc_bad && !inhibit;
      if (nxt == ST_TOPOFF) cv_seen <= 1'b1;
      else if (nxt == ST_OFF || nxt == ST_DONE || nxt == ST_BAD) cv_seen <= 1'b0;
      if (nxt == ST_OFF || (state == ST_DONE && nxt != ST_DONE))
        eoc <= 1'b0;
      else if (nxt == ST_DONE || (state == ST_TOPOFF && nxt == ST_TOPOFF && tenth))
        eoc <= 1'b1;
    end
  end
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_seq_pkg::*;
#(
  parameter int TRICKLE_TICKS = 1800,
  parameter int TERM_TICKS    = 7200,
  parameter int DIP_CYCLES    = 1300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       bat_low_a,
  input  logic       cv_mode_a,
  input  logic       below_rechg_a,
  input  logic       cur_tenth_a,
  input  logic       ntc_hot_a,
  input  logic       ntc_cold_a,
  input  logic       ntc_gnd_a,
  input  logic       uvlo_a,
  input  logic       shdn_a,
  input  logic       susp_a,
  output logic       chg_en,
  output logic       trickle_sel,
  output logic [2:0] chg_state,
  output logic       eoc,
  output logic       bad_bat_flt,
  output logic       ntc_flt
);
  localparam logic [NFLAG-1:0] SYNC_RST =
    (NFLAG'(1) << F_UVLO) | (NFLAG'(1) << F_SHDN) | (NFLAG'(1) << F_SUSP);

  logic [NFLAG-1:0] raw, fs;
  logic inhibit_s, ntc_bad_s;
  logic trk_clr, trk_run, term_clr, term_run, trk_exp, term_exp;
  logic dip_lvl, dip_pulse;
  chg_st_t state;

  assign raw = {susp_a, shdn_a, uvlo_a, ntc_gnd_a, ntc_cold_a, ntc_hot_a,
                cur_tenth_a, below_rechg_a, cv_mode_a, bat_low_a};

  chg_flag_sync #(.W(NFLAG), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(fs));

  assign inhibit_s = fs[F_UVLO] | fs[F_SHDN] | fs[F_SUSP];
  assign ntc_bad_s = (fs[F_HOT] | fs[F_COLD]) & ~fs[F_GND];

  chg_tick_timer #(.LIMIT(TRICKLE_TICKS)) u_trk (
    .clk(clk), .rst(rst), .clr(trk_clr), .run(trk_run), .tick(tick_en), .expired(trk_exp));

  chg_tick_timer #(.LIMIT(TERM_TICKS)) u_term (
    .clk(clk), .rst(rst), .clr(term_clr), .run(term_run), .tick(tick_en), .expired(term_exp));

  chg_dip_filter #(.DIP(DIP_CYCLES)) u_dip (
    .clk(clk), .rst(rst), .below(fs[F_BELOW]), .qual_lvl(dip_lvl), .qual_pulse(dip_pulse));

  chg_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .inhibit(inhibit_s), .low(fs[F_LOW]), .cv(fs[F_CV]),
    .below(fs[F_BELOW]), .tenth(fs[F_TENTH]), .ntc_bad(ntc_bad_s),
    .trk_exp(trk_exp), .term_exp(term_exp), .dip_lvl(dip_lvl), .dip_pulse(dip_pulse),
    .state(state), .trk_clr(trk_clr), .trk_run(trk_run), .term_clr(term_clr),
    .term_run(term_run), .chg_en(chg_en), .trickle_sel(trickle_sel), .eoc(eoc),
    .bad_flt(bad_bat_flt), .ntc_flt(ntc_flt));

  assign chg_state = state;
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       shdn_a,
  input logic       inhibit_s,
  input logic       chg_en,
  input logic       trickle_sel,
  input logic [2:0] chg_state,
  input logic       eoc,
  input logic       bad_bat_flt
);
  p_shdn_off_r1: assert property (@(posedge clk) disable iff (rst)
    shdn_a && $past(shdn_a) && $past(shdn_a, 2) |=> (chg_state == 3'd0) && !chg_en);

  p_trickle_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    trickle_sel |-> chg_en);

  p_bad_latched_r3: assert property (@(posedge clk) disable iff (rst)
    (chg_state == 3'd5) && !inhibit_s |=> (chg_state == 3'd5));

  p_bad_excl_en_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bad_bat_flt, chg_en}));

  p_done_off_r5: assert property (@(posedge clk) disable iff (rst)
    (chg_state == 3'd4) |-> !chg_en);

  p_eoc_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc) |-> (chg_state == 3'd3) || (chg_state == 3'd4));

  p_hold_off_r9: assert property (@(posedge clk) disable iff (rst)
    (chg_state == 3'd6) |-> !chg_en);
endmodule

bind chg_seq_top chg_seq_chk u_chk (
  .clk(clk), .rst(rst), .shdn_a(shdn_a), .inhibit_s(inhibit_s), .chg_en(chg_en),
  .trickle_sel(trickle_sel), .chg_state(chg_state), .eoc(eoc), .bad_bat_flt(bad_bat_flt));

// File: tb/sim_chg_seq_top.sv
module sim_chg_seq_top;
  localparam int TRK  = 5;
  localparam int TERM = 8;
  localparam int DIP  = 4;
  localparam int S_OFF = 0, S_TRK = 1, S_FAST = 2, S_TOP = 3, S_DONE = 4, S_BAD = 5, S_HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic low = 1'b0, cv = 1'b0, below = 1'b0, tenth = 1'b0;
  logic hot = 1'b0, cold = 1'b0, gnd = 1'b0, uvlo = 1'b0, shdn = 1'b1, susp = 1'b0;
  logic chg_en, trickle_sel, eoc, bad_flt, ntc_flt;
  logic [2:0] st;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chg_seq_top #(.TRICKLE_TICKS(TRK), .TERM_TICKS(TERM), .DIP_CYCLES(DIP)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bat_low_a(low), .cv_mode_a(cv),
    .below_rechg_a(below), .cur_tenth_a(tenth), .ntc_hot_a(hot), .ntc_cold_a(cold),
    .ntc_gnd_a(gnd), .uvlo_a(uvlo), .shdn_a(shdn), .susp_a(susp), .chg_en(chg_en),
    .trickle_sel(trickle_sel), .chg_state(st), .eoc(eoc), .bad_bat_flt(bad_flt),
    .ntc_flt(ntc_flt));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // qualified recharge dip, long enough to pass the filter
  task automatic dip();
    below = 1'b1; cyc(DIP + 1); below = 1'b0; cyc(4);
  endtask

  // from FAST with cv already high or low: reach DONE through a full timer
  task automatic run_to_done();
    cv = 1'b1; cyc(4);
    repeat (TERM) tick();
    cyc(2); cv = 1'b0; cyc(4);
  endtask

  initial begin
    cyc(3);
    check("R1 reset state", st, S_OFF);
    check("R1 reset chg_en", chg_en, 0);
    check("R1 reset eoc", eoc, 0);
    check("R1 reset bad", bad_flt, 0);
    rst = 1'b0; cyc(6);
    check("R1 shutdown held", st, S_OFF);
    check("R1 shutdown chg_en", chg_en, 0);

    // R2: trickle start, R4: leave trickle
    low = 1'b1; shdn = 1'b0; cyc(4);
    check("R2 trickle state", st, S_TRK);
    check("R2 trickle chg_en", chg_en, 1);
    check("R2 trickle_sel", trickle_sel, 1);
    low = 1'b0; cyc(4);
    check("R4 to fast", st, S_FAST);
    check("R4 trickle_sel off", trickle_sel, 0);

    // R5: no counting in FAST, then sweep termination timer
    repeat (3) tick();
    cv = 1'b1; cyc(4);
    check("R5 topoff entry", st, S_TOP);
    tenth = 1'b1; cyc(4);
    check("R6 eoc in topoff", eoc, 1);
    check("R6 still charging", chg_en, 1);
    for (int n = 1; n <= TERM; n++) begin
      tick(); cyc(2);
      check("R5 timer sweep", st, (n >= TERM) ? S_DONE : S_TOP);
    end
    check("R5 done chg_en", chg_en, 0);
    check("R6 eoc in done", eoc, 1);
    cv = 1'b0; tenth = 1'b0; cyc(4);

    // R7: dip length sweep
    for (int len = 1; len <= DIP + 1; len++) begin
      below = 1'b1; cyc(len); below = 1'b0; cyc(4);
      if (len >= DIP) begin
        check("R7 long dip restarts", st, S_FAST);
        check("R6 eoc cleared on restart", eoc, 0);
        run_to_done();
      end else begin
        check("R7 short dip ignored", st, S_DONE);
      end
    end

    // R8: qualified dip in TOPOFF resets timer
    dip();
    check("R8 restart", st, S_FAST);
    cv = 1'b1; cyc(4);
    repeat (TERM - 2) tick();
    dip();
    check("R8 still topoff after dip", st, S_TOP);
    repeat (TERM - 1) tick();
    cyc(2);
    check("R8 timer restarted", st, S_TOP);
    tick(); cyc(2);
    check("R8 expire after full count", st, S_DONE);
    cv = 1'b0; cyc(4);

    // R9: hold freezes timer
    dip();
    cv = 1'b1; cyc(4);
    repeat (3) tick();
    hot = 1'b1; cyc(4);
    check("R9 hold state", st, S_HOLD);
    check("R9 hold chg_en", chg_en, 0);
    check("R9 ntc_flt", ntc_flt, 1);
    repeat (10) tick();
    cyc(2);
    check("R9 hold persists", st, S_HOLD);
    below = 1'b1; hot = 1'b0; cyc(1); below = 1'b0; cyc(4);
    check("R9 resume topoff", st, S_TOP);
    check("R9 ntc_flt cleared", ntc_flt, 0);
    repeat (TERM - 4) tick();
    cyc(2);
    check("R9 timer held not cleared", st, S_TOP);
    tick(); cyc(2);
    check("R9 remaining ticks expire", st, S_DONE);
    cv = 1'b0; cyc(4);

    // R10: recovery above recharge level
    dip();
    check("R10 restart", st, S_FAST);
    cold = 1'b1; cyc(4);
    check("R10 hold", st, S_HOLD);
    cold = 1'b0; cyc(4);
    check("R10 done after recovery", st, S_DONE);
    check("R10 chg_en off", chg_en, 0);

    // R11: grounded thermistor masks faults
    dip();
    gnd = 1'b1; hot = 1'b1; cyc(4);
    check("R11 masked state", st, S_FAST);
    check("R11 ntc_flt masked", ntc_flt, 0);
    check("R11 chg_en kept", chg_en, 1);
    hot = 1'b0; gnd = 1'b0; cyc(4);

    // R12: lockout cycle clears timer
    cv = 1'b1; cyc(4);
    repeat (TERM - 1) tick();
    uvlo = 1'b1; cyc(4);
    check("R12 lockout off", st, S_OFF);
    check("R12 lockout chg_en", chg_en, 0);
    uvlo = 1'b0; cyc(4);
    check("R12 restart topoff", st, S_TOP);
    repeat (TERM - 1) tick();
    cyc(2);
    check("R12 timer cleared", st, S_TOP);
    tick(); cyc(2);
    check("R12 expire", st, S_DONE);
    cv = 1'b0;

    // R13: shutdown clears eoc
    shdn = 1'b1; cyc(4);
    check("R13 eoc cleared", eoc, 0);
    check("R13 state off", st, S_OFF);

    // R3: bad battery sweep
    low = 1'b1; shdn = 1'b0; cyc(4);
    for (int n = 1; n <= TRK; n++) begin
      tick(); cyc(2);
      check("R3 trickle sweep", st, (n >= TRK) ? S_BAD : S_TRK);
    end
    low = 1'b0; cyc(4);
    check("R3 bad latched", st, S_BAD);
    check("R3 bad flag", bad_flt, 1);
    check("R3 bad chg_en", chg_en, 0);
    susp = 1'b1; cyc(4);
    check("R1 suspend clears", st, S_OFF);
    check("R3 fault cleared", bad_flt, 0);
    susp = 1'b0; cyc(4);
    check("R2 fast start", st, S_FAST);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule